// File: doc/BRIEF.md
# Locality-Predicted Crossbar Bypass Stage

This block is the switch-traversal stage of a five-port mesh router. Every output port can be fed from two places. One is the ordinary path: a flit that has been buffered in an input virtual channel and granted the output by the switch allocator. The other is a shortcut: a flit taken straight off a router input port in the cycle it arrives. The shortcut skips the buffer write, VC allocation and switch allocation.

Each output keeps a small prediction register. It records which input last sent a latency-critical flit through that output. When a critical flit arrives on the recorded input and heads for that output, and the downstream router still has a free virtual channel, the flit takes the shortcut. Its VC field is rewritten to the lowest-numbered free downstream VC. The prediction comes from traffic history, not from the input being idle, so the shortcut keeps working when the router is busy.

The upstream buffer logic uses the per-input consumed flag to decide whether an arriving flit still has to be written to its VC buffer. The switch allocator uses the per-output blocked flag to retry a displaced grant in the next cycle.

Top module: `lcb_xbar_bypass`

## Requirements
- R1: After reset, every output is invalid and every prediction register is empty. No flit can take the shortcut on an output until a critical flit has left that output by the buffered path.
- R2: When a critical flit leaves an output by either path, that output's prediction register takes the flit's input index. A non-critical flit leaving an output leaves the register unchanged.
- R3: A hit on output o means four things in one cycle: a valid input flit is critical, its destination field equals o, o's prediction register is filled, and the register names that flit's input.
- R4: A hit on an output whose downstream VC free mask is non-zero takes the shortcut. One cycle later that output shows the input flit, with out_valid=1 and out_bypass=1.
- R5: A flit taking the shortcut leaves with its low VC_W bits (the VC field, bits [2:0] by default) replaced by the index of the lowest set bit of that output's downstream free mask. All other bits are unchanged.
- R6: An output with a valid switch grant and no conflict shows the granted input's buffered flit one cycle later, bit for bit, with out_valid=1 and out_bypass=0.
- R7: When an output takes the shortcut in the same cycle that it holds a switch grant, the grant is not served and sa_blocked for that output is 1.
- R8: An input whose flit takes the shortcut has in_bypassed=1. Any switch grant that names that input on another output is suppressed, and that output's sa_blocked is 1.
- R9: A critical flit that misses, or that hits while the output's downstream free mask is all zero, does not take the shortcut (in_bypassed=0). The output serves its switch grant, if any.
- R10: A non-critical flit never takes the shortcut, even when its input and destination match the prediction.
- R11: The output flits are registered. An output with neither a shortcut nor a served grant has out_valid=0 in the next cycle. in_bypassed and sa_blocked are combinational, valid in the same cycle as their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | PORTS | Arriving flit present, per input |
| in_crit | input | PORTS | Latency-critical tag of arriving flit, per input |
| in_dest | input | PORTS*PW | Destination output index of arriving flit, per input |
| in_flit | input | PORTS*FLIT_W | Arriving flit, per input |
| buf_crit | input | PORTS | Critical tag of the buffered head flit, per input |
| buf_flit | input | PORTS*FLIT_W | Buffered head flit selected for traversal, per input |
| sa_grant_valid | input | PORTS | Switch grant present, per output |
| sa_grant_src | input | PORTS*PW | Granted input index, per output |
| dn_vc_free | input | PORTS*NUM_VC | Downstream VCs with credit, per output |
| in_bypassed | output | PORTS | Arriving flit taken by the shortcut this cycle, per input |
| sa_blocked | output | PORTS | Switch grant not served this cycle, per output |
| out_valid | output | PORTS | Output flit valid, per output |
| out_bypass | output | PORTS | Output flit came by the shortcut, per output |
| out_flit | output | PORTS*FLIT_W | Output flit, per output |

## Verification
The two functions that can land on the same output in the same cycle are a prediction hit and a switch grant. A hit on one output can also collide with a grant that the same input holds on a different output. The bench provokes both collisions on purpose. It first trains a prediction register with a buffered critical flit. It then presents a matching critical flit together with a grant to that output from another input, or together with a grant for the same input on another output. A long sweep then produces such collisions at random under biased destinations. In every cycle, an independent model in the bench predicts sa_blocked and in_bypassed. It also predicts which flit, with which VC field, each output shows one cycle later.

// File: rtl/lcb_pkg.sv
// Shared definitions for the locality-predicted crossbar bypass stage.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lcb_pkg;

    // Default geometry of the router.
    localparam int unsigned LCB_DEF_PORTS  = 5;
    localparam int unsigned LCB_DEF_FLIT_W = 64;
    localparam int unsigned LCB_DEF_NUM_VC = 5;

    // Which source fed an output register.
    typedef enum logic {
        PATH_BUFFERED = 1'b0,
        PATH_SHORTCUT = 1'b1
    } path_e;

endpackage

// File: rtl/lcb_vc_pick.sv
// Picks the downstream VC a shortcut flit is stamped with: the lowest-indexed
// VC that still has credit. No load balancing is done, because critical
// packets are short. Pure combinational logic, one instance per output.
module lcb_vc_pick #(
    parameter int unsigned NUM_VC = 5,
    parameter int unsigned VC_W   = 3
) (
    input  logic [NUM_VC-1:0] vc_free,
    output logic              vc_avail,
    output logic [VC_W-1:0]   vc_idx
);

    // Any downstream VC with credit enables the shortcut.
    assign vc_avail = |vc_free;

    // Priority scan from the top, so the lowest free index wins.
    always_comb begin
        vc_idx = '0;
        for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (vc_free[v]) vc_idx = VC_W'(v);
        end
    end

    // The chosen VC is free and no lower VC is free.
    always_comb begin
        if (vc_avail) begin
            assert_lowest_free_R5: assert (vc_free[vc_idx] &&
                ((vc_free & ((NUM_VC'(1) << vc_idx) - NUM_VC'(1))) == '0));
        end
    end

endmodule

// File: rtl/lcb_locality_reg.sv
// Prediction register for one output. It remembers the input of the last
// critical flit that left this output and flags a hit when a critical flit
// from that input targets this output again. Assumes in_dest is the
// destination output index computed ahead of this stage.
module lcb_locality_reg #(
    parameter int unsigned PORTS   = 5,
    parameter int unsigned PW      = 3,
    parameter int unsigned OUT_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORTS-1:0]   in_valid,
    input  logic [PORTS-1:0]   in_crit,
    input  logic [PORTS*PW-1:0] in_dest,
    input  logic               upd_en,
    input  logic [PW-1:0]      upd_src,
    output logic               hit,
    output logic [PW-1:0]      loc_src
);

    logic loc_valid;

    // Capture the source of every critical flit that leaves this output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_valid <= 1'b0;
            loc_src   <= '0;
        end else if (upd_en) begin
            loc_valid <= 1'b1;
            loc_src   <= upd_src;
        end
    end

    // Hit when the recorded input presents a critical flit for this output.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < PORTS; i++) begin
            if (loc_valid && loc_src == PW'(i) && in_valid[i] && in_crit[i] &&
                in_dest[i*PW +: PW] == PW'(OUT_IDX)) begin
                hit = 1'b1;
            end
        end
    end

    assert_update_takes_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (loc_valid && loc_src == $past(upd_src)));

    assert_empty_never_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_valid |-> !hit);

endmodule

// File: rtl/lcb_out_stage.sv
// Output half of one crossbar column. A 2:1 choice between the shortcut flit
// (with its VC field restamped) and the granted buffered flit, followed by
// the output register. Also reports which critical flit left, so the
// prediction register can learn. Assumes byp_sel and buf_ok never coincide.
module lcb_out_stage
    import lcb_pkg::*;
#(
    parameter int unsigned PORTS  = 5,
    parameter int unsigned PW     = 3,
    parameter int unsigned FLIT_W = 64,
    parameter int unsigned VC_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byp_sel,
    input  logic [PW-1:0]           byp_src,
    input  logic [VC_W-1:0]         byp_vc,
    input  logic                    buf_ok,
    input  logic [PW-1:0]           buf_src,
    input  logic [PORTS*FLIT_W-1:0] in_flit,
    input  logic [PORTS*FLIT_W-1:0] buf_flit,
    input  logic [PORTS-1:0]        buf_crit,
    output logic                    out_valid,
    output logic                    out_bypass,
    output logic [FLIT_W-1:0]       out_flit,
    output logic                    upd_en,
    output logic [PW-1:0]           upd_src
);

    logic [FLIT_W-1:0] byp_raw;
    logic [FLIT_W-1:0] buf_raw;
    logic              buf_crit_sel;
    logic [FLIT_W-1:0] nxt_flit;
    path_e             nxt_path;
    path_e             out_path;

    // Column multiplexers over the inputs, one per source.
    always_comb begin
        byp_raw      = '0;
        buf_raw      = '0;
        buf_crit_sel = 1'b0;
        for (int i = 0; i < PORTS; i++) begin
            if (byp_src == PW'(i)) byp_raw = in_flit[i*FLIT_W +: FLIT_W];
            if (buf_src == PW'(i)) begin
                buf_raw      = buf_flit[i*FLIT_W +: FLIT_W];
                buf_crit_sel = buf_crit[i];
            end
        end
    end

    // Final 2:1 selection, restamping the VC field on the shortcut.
    always_comb begin
        if (byp_sel) begin
            nxt_flit             = byp_raw;
            nxt_flit[VC_W-1:0]   = byp_vc;
            nxt_path             = PATH_SHORTCUT;
        end else begin
            nxt_flit = buf_raw;
            nxt_path = PATH_BUFFERED;
        end
    end

    // Tell the prediction register which critical flit leaves this cycle.
    always_comb begin
        upd_en  = byp_sel || (buf_ok && buf_crit_sel);
        upd_src = byp_sel ? byp_src : buf_src;
    end

    // Output register of the traversal stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_flit  <= '0;
            out_path  <= PATH_BUFFERED;
        end else begin
            out_valid <= byp_sel || buf_ok;
            out_flit  <= nxt_flit;
            out_path  <= nxt_path;
        end
    end

    assign out_bypass = out_valid && (out_path == PATH_SHORTCUT);

    assert_shortcut_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byp_sel |=> (out_valid && out_bypass));

    assert_grant_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_ok && !byp_sel) |=> (out_valid && !out_bypass));

    assert_sources_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byp_sel |-> !buf_ok);

    assert_idle_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_sel && !buf_ok) |=> !out_valid);

endmodule

// File: rtl/lcb_xbar_bypass.sv
// Switch-traversal stage with a history-predicted shortcut for critical flits.
// Per output: a prediction register, a downstream VC picker and an output
// stage. Across outputs: it finds which inputs the shortcut consumes and
// which switch grants must be deferred. Assumes one destination per input
// flit and at most one switch grant per output.
module lcb_xbar_bypass
    import lcb_pkg::*;
#(
    parameter int unsigned PORTS  = LCB_DEF_PORTS,
    parameter int unsigned FLIT_W = LCB_DEF_FLIT_W,
    parameter int unsigned NUM_VC = LCB_DEF_NUM_VC,
    localparam int unsigned PW    = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int unsigned VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PORTS-1:0]         in_valid,
    input  logic [PORTS-1:0]         in_crit,
    input  logic [PORTS*PW-1:0]      in_dest,
    input  logic [PORTS*FLIT_W-1:0]  in_flit,
    input  logic [PORTS-1:0]         buf_crit,
    input  logic [PORTS*FLIT_W-1:0]  buf_flit,
    input  logic [PORTS-1:0]         sa_grant_valid,
    input  logic [PORTS*PW-1:0]      sa_grant_src,
    input  logic [PORTS*NUM_VC-1:0]  dn_vc_free,
    output logic [PORTS-1:0]         in_bypassed,
    output logic [PORTS-1:0]         sa_blocked,
    output logic [PORTS-1:0]         out_valid,
    output logic [PORTS-1:0]         out_bypass,
    output logic [PORTS*FLIT_W-1:0]  out_flit
);

    logic [PORTS-1:0] hit;
    logic [PORTS-1:0] vc_avail;
    logic [PORTS-1:0] byp_sel;
    logic [PORTS-1:0] buf_ok;
    logic [PORTS-1:0] upd_en;
    logic [PW-1:0]    loc_src [PORTS];
    logic [PW-1:0]    upd_src [PORTS];
    logic [VC_W-1:0]  byp_vc  [PORTS];
    logic [PORTS-1:0] take_m  [PORTS];

    // Per-output prediction, VC pick and output register.
    for (genvar o = 0; o < PORTS; o++) begin : g_out
        lcb_locality_reg #(
            .PORTS(PORTS), .PW(PW), .OUT_IDX(o)
        ) u_loc (
            .clk(clk), .rst_n(rst_n),
            .in_valid(in_valid), .in_crit(in_crit), .in_dest(in_dest),
            .upd_en(upd_en[o]), .upd_src(upd_src[o]),
            .hit(hit[o]), .loc_src(loc_src[o])
        );

        lcb_vc_pick #(
            .NUM_VC(NUM_VC), .VC_W(VC_W)
        ) u_vc (
            .vc_free(dn_vc_free[o*NUM_VC +: NUM_VC]),
            .vc_avail(vc_avail[o]), .vc_idx(byp_vc[o])
        );

        // Shortcut select: critical hit with a free downstream VC.
        assign byp_sel[o] = hit[o] && vc_avail[o];

        lcb_out_stage #(
            .PORTS(PORTS), .PW(PW), .FLIT_W(FLIT_W), .VC_W(VC_W)
        ) u_stage (
            .clk(clk), .rst_n(rst_n),
            .byp_sel(byp_sel[o]), .byp_src(loc_src[o]), .byp_vc(byp_vc[o]),
            .buf_ok(buf_ok[o]), .buf_src(sa_grant_src[o*PW +: PW]),
            .in_flit(in_flit), .buf_flit(buf_flit), .buf_crit(buf_crit),
            .out_valid(out_valid[o]), .out_bypass(out_bypass[o]),
            .out_flit(out_flit[o*FLIT_W +: FLIT_W]),
            .upd_en(upd_en[o]), .upd_src(upd_src[o])
        );

        assert_needs_free_vc_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_bypass[o] |-> $past(dn_vc_free[o*NUM_VC +: NUM_VC] != '0));

        assert_hit_defers_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (sa_blocked[o] && byp_sel[o]) |=> out_bypass[o]);

        assert_dry_vc_no_shortcut_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_vc_free[o*NUM_VC +: NUM_VC] == '0) |=> !out_bypass[o]);
    end

    // Input-by-output matrix of shortcut consumption.
    for (genvar i = 0; i < PORTS; i++) begin : g_in
        always_comb begin
            for (int o = 0; o < PORTS; o++) begin
                take_m[i][o] = byp_sel[o] && (loc_src[o] == PW'(i));
            end
        end

        // An input is consumed when any output takes its flit by shortcut.
        assign in_bypassed[i] = |take_m[i];

        assert_single_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(take_m[i]));

        assert_plain_flit_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !in_crit[i] |-> !in_bypassed[i]);
    end

    // Serve a grant only if its output and its input are both untouched.
    always_comb begin
        for (int o = 0; o < PORTS; o++) begin
            logic src_busy;
            logic src_legal;
            src_busy  = 1'b0;
            src_legal = 1'b0;
            for (int i = 0; i < PORTS; i++) begin
                if (sa_grant_src[o*PW +: PW] == PW'(i)) begin
                    src_legal = 1'b1;
                    src_busy  = in_bypassed[i];
                end
            end
            buf_ok[o]     = sa_grant_valid[o] && src_legal && !byp_sel[o] && !src_busy;
            sa_blocked[o] = sa_grant_valid[o] && !buf_ok[o];
        end
    end

endmodule

// File: tb/lcb_xbar_bypass_bench.sv
`timescale 1ns/1ps
module lcb_xbar_bypass_bench;

    localparam int P  = 5;
    localparam int FW = 64;
    localparam int NV = 5;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [P-1:0]    in_valid, in_crit, buf_crit, sa_grant_valid;
    logic [P*PW-1:0] in_dest, sa_grant_src;
    logic [P*FW-1:0] in_flit, buf_flit;
    logic [P*NV-1:0] dn_vc_free;
    logic [P-1:0]    in_bypassed, sa_blocked, out_valid, out_bypass;
    logic [P*FW-1:0] out_flit;

    lcb_xbar_bypass u_lcb_xbar_bypass (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_crit(in_crit), .in_dest(in_dest), .in_flit(in_flit),
        .buf_crit(buf_crit), .buf_flit(buf_flit),
        .sa_grant_valid(sa_grant_valid), .sa_grant_src(sa_grant_src),
        .dn_vc_free(dn_vc_free),
        .in_bypassed(in_bypassed), .sa_blocked(sa_blocked),
        .out_valid(out_valid), .out_bypass(out_bypass), .out_flit(out_flit)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Stimulus fields.
    bit          iv[P], ic[P], bc[P], gv[P];
    int          dst[P], gs[P];
    logic [63:0] ifl[P], bfl[P];
    logic [4:0]  fr[P];

    // Independent model state and expected registered outputs.
    bit          m_v[P];
    int          m_src[P];
    bit          e_valid[P], e_byp[P];
    logic [63:0] e_flit[P];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic clear_in();
        for (int i = 0; i < P; i++) begin
            iv[i] = 0; ic[i] = 0; bc[i] = 0; gv[i] = 0;
            dst[i] = 0; gs[i] = 0; ifl[i] = '0; bfl[i] = '0; fr[i] = 5'b11111;
        end
    endtask

    task automatic pack();
        for (int i = 0; i < P; i++) begin
            in_valid[i] = iv[i]; in_crit[i] = ic[i]; buf_crit[i] = bc[i];
            sa_grant_valid[i] = gv[i];
            in_dest[i*PW +: PW] = PW'(dst[i]);
            sa_grant_src[i*PW +: PW] = PW'(gs[i]);
            in_flit[i*FW +: FW] = ifl[i];
            buf_flit[i*FW +: FW] = bfl[i];
            dn_vc_free[i*NV +: NV] = fr[i];
        end
    endtask

    task automatic check_regs(input string tag);
        for (int o = 0; o < P; o++) begin
            string t;
            t = (tag != "") ? tag : (e_byp[o] ? "R4" : (e_valid[o] ? "R6" : "R11"));
            chk(out_valid[o] == e_valid[o] && out_bypass[o] == e_byp[o], t,
                $sformatf("out%0d valid/bypass", o),
                64'({out_valid[o], out_bypass[o]}), 64'({e_valid[o], e_byp[o]}));
            if (e_valid[o])
                chk(out_flit[o*FW +: FW] === e_flit[o], e_byp[o] ? "R5" : "R6",
                    $sformatf("out%0d flit", o), out_flit[o*FW +: FW], e_flit[o]);
        end
    endtask

    // Apply stimulus, judge same-cycle flags, advance the model and clock.
    task automatic run_cycle(input string tag);
        bit byp[P], cons[P], ok[P];
        int vcl[P];
        pack();
        #1;
        for (int o = 0; o < P; o++) begin
            int s;
            s = m_src[o];
            vcl[o] = 0;
            for (int v = NV - 1; v >= 0; v--) if (fr[o][v]) vcl[o] = v;
            byp[o] = m_v[o] && iv[s] && ic[s] && dst[s] == o && fr[o] != 0;
        end
        for (int i = 0; i < P; i++) begin
            cons[i] = 0;
            for (int o = 0; o < P; o++) if (byp[o] && m_src[o] == i) cons[i] = 1;
        end
        for (int i = 0; i < P; i++) begin
            string t;
            t = (tag != "") ? tag : (cons[i] ? "R3" : (ic[i] ? "R9" : "R10"));
            chk(in_bypassed[i] == cons[i], t, $sformatf("in%0d consumed", i),
                64'(in_bypassed[i]), 64'(cons[i]));
        end
        for (int o = 0; o < P; o++) begin
            ok[o] = gv[o] && !byp[o] && !cons[gs[o]];
            chk(sa_blocked[o] == (gv[o] && !ok[o]), (tag != "") ? tag : (byp[o] ? "R7" : "R8"),
                $sformatf("out%0d blocked", o), 64'(sa_blocked[o]), 64'(gv[o] && !ok[o]));
        end
        for (int o = 0; o < P; o++) begin
            e_valid[o] = byp[o] || ok[o];
            e_byp[o]   = byp[o];
            if (byp[o]) e_flit[o] = {ifl[m_src[o]][63:3], 3'(vcl[o])};
            else if (ok[o]) e_flit[o] = bfl[gs[o]];
            else e_flit[o] = '0;
            if (ok[o] && bc[gs[o]]) begin
                m_v[o] = 1; m_src[o] = gs[o];
            end
        end
        @(posedge clk);
        @(negedge clk);
        check_regs(tag);
    endtask

    task automatic crit_in(input int i, input int d, input logic [63:0] f);
        iv[i] = 1; ic[i] = 1; dst[i] = d; ifl[i] = f;
    endtask

    task automatic grant(input int o, input int s, input bit crit, input logic [63:0] f);
        gv[o] = 1; gs[o] = s; bc[s] = crit; bfl[s] = f;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        int pref[P];
        clear_in();
        pack();
        for (int o = 0; o < P; o++) begin
            m_v[o] = 0; m_src[o] = 0; e_valid[o] = 0; e_byp[o] = 0; e_flit[o] = '0;
        end
        repeat (3) @(negedge clk);
        check_regs("R1");
        rst_n = 1'b1;

        // R1: a matching-looking critical flit cannot bypass an empty predictor.
        clear_in(); crit_in(1, 0, 64'h1111_0000_0000_0007);
        run_cycle("R1");
        // Train output 0 with a buffered critical flit from input 1 (R2).
        clear_in(); grant(0, 1, 1, 64'hB1B1_0000_0000_0002);
        run_cycle("R2");
        // R3: critical flit from input 1 to output 0 now bypasses.
        clear_in(); crit_in(1, 0, 64'hC0DE_0000_0000_0005);
        run_cycle("R3");
        // R2: non-critical buffered flit from input 2 leaves the prediction alone.
        clear_in(); grant(0, 2, 0, 64'h2222_0000_0000_0001);
        run_cycle("R2");
        clear_in(); crit_in(1, 0, 64'hC0DE_0000_0000_0006);
        run_cycle("R2");
        // R5: lowest free VC is 2 with mask 10100.
        clear_in(); crit_in(1, 0, 64'hFFFF_FFFF_FFFF_FFFF); fr[0] = 5'b10100;
        run_cycle("R5");
        // R9: hit with no free downstream VC goes the buffered way.
        clear_in(); crit_in(1, 0, 64'h9999_0000_0000_0000); fr[0] = 5'b00000;
        grant(0, 3, 0, 64'h3333_0000_0000_0004);
        run_cycle("R9");
        // R9: critical flit on a different input misses.
        clear_in(); crit_in(4, 0, 64'h4444_0000_0000_0000);
        run_cycle("R9");
        // R7: hit and grant on the same output; grant deferred.
        clear_in(); crit_in(1, 0, 64'h7777_0000_0000_0001);
        grant(0, 3, 1, 64'h3030_0000_0000_0003);
        run_cycle("R7");
        // R8: input 1 bypasses to 0 while also granted output 3.
        clear_in(); crit_in(1, 0, 64'h8888_0000_0000_0000);
        grant(3, 1, 0, 64'h8181_0000_0000_0002);
        grant(2, 4, 0, 64'h4242_0000_0000_0001);
        run_cycle("R8");
        // R10: non-critical flit with matching input and destination stays put.
        clear_in(); iv[1] = 1; ic[1] = 0; dst[1] = 0; ifl[1] = 64'hA0A0_0000_0000_0000;
        run_cycle("R10");
        // R11: idle cycle clears every output.
        clear_in();
        run_cycle("R11");

        // Sweep with destinations biased toward a per-input favourite.
        for (int i = 0; i < P; i++) pref[i] = (i + 1) % P;
        for (int c = 0; c < 6000; c++) begin
            bit used[P];
            if (c % 250 == 0) for (int i = 0; i < P; i++) pref[i] = $urandom_range(P - 1);
            clear_in();
            for (int i = 0; i < P; i++) used[i] = 0;
            for (int i = 0; i < P; i++) begin
                iv[i]  = ($urandom_range(3) != 0);
                ic[i]  = $urandom_range(1);
                bc[i]  = $urandom_range(1);
                dst[i] = ($urandom_range(9) < 7) ? pref[i] : $urandom_range(P - 1);
                ifl[i] = {$urandom, $urandom};
                bfl[i] = {$urandom, $urandom};
            end
            for (int o = 0; o < P; o++) begin
                int s;
                s = $urandom_range(P - 1);
                fr[o] = ($urandom_range(4) == 0) ? 5'b00000 : 5'($urandom_range(31));
                if ($urandom_range(1) == 1 && !used[s]) begin
                    gv[o] = 1; gs[o] = s; used[s] = 1;
                end
            end
            run_cycle("");
        end
        done = 1;
        finish_run();
    end

endmodule